// File: doc/BRIEF.md
# Antenna Phase Meter

This block measures how far the digitized antenna-tap signal lags the driver excitation. A free-running step counter is cleared at every rising edge of the carrier reference and advanced by a phase-step tick that arrives 64 times per carrier period. The step count at the first rising edge of the tap comparator is the lag of that period in units of 5.625 degrees. With a correctly tuned antenna, the lag reads 16, which is a quarter period.

Each completed period's result is moved into the readable phase code at the next carrier rising edge. If a period has no tap edge, the previous code is kept. The same step counter also drives a demodulator sample strobe. This strobe is a single-clock pulse that fires when the counter reaches a programmable 6-bit sampling time. The sampling time is written through a one-cycle write port and can always be read back. The two asynchronous inputs pass through a parameterized synchronizer before their rising edges are detected.

Top module: `antenna_phase_meter`

## Requirements
- R1: While reset is asserted and just after it is released, the phase code is 0, the sampling time reads 0 and the sample strobe is low.
- R2: The phase code of a period is the number of step ticks counted from that period's carrier rising edge up to its first tap rising edge. The value lies between 0 and 63, and a quarter-period lag gives 16.
- R3: The phase code changes only as a consequence of a carrier rising edge. It stays constant for the whole of the following period, and all of its bits change together.
- R4: A period without any tap rising edge leaves the phase code at its previous value.
- R5: Only the first tap rising edge in a period is counted; later edges in the same period are ignored.
- R6: A tap rising edge detected in the same cycle as a carrier rising edge belongs to the new period and yields code 0. The period that just ended is still latched.
- R7: Tap edges that arrive before the first carrier rising edge after reset never reach the phase code.
- R8: Pulsing the write enable for one clock with a 6-bit value makes the sampling-time output equal that value from the next clock on.
- R9: The sample strobe is high for exactly one clock per carrier period. It rises in the cycle in which the step counter first takes the value equal to the sampling time; sampling time 0 fires on the wrap to step 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_tick | input | 1 | One-clock pulse, 64 per carrier period, advances the step counter |
| carrier_ref | input | 1 | Carrier reference level, rising edge starts a period |
| tap_cmp | input | 1 | Antenna-tap comparator output |
| samp_wr_en | input | 1 | Sampling-time write strobe |
| samp_wr_data | input | STEP_W | Sampling time to write |
| phase_code | output | STEP_W | Latched phase lag of the last complete period |
| samp_time | output | STEP_W | Current sampling time |
| sample_strobe | output | 1 | One-clock demodulator sample pulse |

## Verification
The period boundary is where two functions share a cycle: latching the finished period's result, and arming capture for the new period. When the tap edge coincides with the carrier edge, the same edge both closes one measurement and opens the next. The bench provokes this by driving a tap rise at step 0 right after a period whose edge came at step 45. The code must read 45 during that period and 0 during the one after it. Neither value may be lost or overwritten, and the code must not move between boundaries.

// File: rtl/apm_pkg.sv
`timescale 1ns/1ps
package apm_pkg;
   localparam int APM_STEP_W_DEF = 6;
   localparam int APM_SYNC_DEF   = 2;

   function automatic logic rose(input logic now_v, input logic prev_v);
      return now_v & ~prev_v;
   endfunction
endpackage

// File: rtl/apm_sync.sv
`timescale 1ns/1ps
module apm_sync #(
   parameter int N_BITS = 2,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_BITS-1:0] async_i,
   output logic [N_BITS-1:0] sync_o
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("apm_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_bypass
         assign sync_o = async_i;
      end else begin : g_chain
         logic [N_BITS-1:0] stg_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
            end else begin
               stg_q[0] <= async_i;
               for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            end
         end
         assign sync_o = stg_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/apm_step_timer.sv
`timescale 1ns/1ps
module apm_step_timer #(
   parameter int STEP_W = apm_pkg::APM_STEP_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_tick,
   input  logic              period_start,
   input  logic [STEP_W-1:0] samp_time,
   output logic [STEP_W-1:0] step_cnt,
   output logic              strobe
);
   logic [STEP_W-1:0] cnt_q, cnt_nxt;
   logic              strobe_q;

   always_comb begin
      if (period_start)   cnt_nxt = '0;
      else if (step_tick) cnt_nxt = cnt_q + 1'b1;
      else                cnt_nxt = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         cnt_q    <= cnt_nxt;
         strobe_q <= (cnt_nxt != cnt_q) && (cnt_nxt == samp_time);
      end
   end

   assign step_cnt = cnt_q;
   assign strobe   = strobe_q;

   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_q |=> !strobe_q); // R9
   AST_STROBE_AT_SAMP: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_q |-> (cnt_q == $past(samp_time))); // R9
   AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      period_start |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/apm_phase_capture.sv
`timescale 1ns/1ps
module apm_phase_capture #(
   parameter int STEP_W = apm_pkg::APM_STEP_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              period_start,
   input  logic              tap_rise,
   input  logic [STEP_W-1:0] step_cnt,
   output logic [STEP_W-1:0] code
);
   logic              synced_q, seen_q;
   logic [STEP_W-1:0] cap_q, code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         synced_q <= 1'b0;
         seen_q   <= 1'b0;
         cap_q    <= '0;
         code_q   <= '0;
      end else if (period_start) begin
         if (synced_q && seen_q) code_q <= cap_q;
         synced_q <= 1'b1;
         seen_q   <= tap_rise;
         cap_q    <= '0;
      end else if (tap_rise && synced_q && !seen_q) begin
         seen_q <= 1'b1;
         cap_q  <= step_cnt;
      end
   end

   assign code = code_q;

   AST_CODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_q) |-> $past(period_start)); // R3
   AST_FIRST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !period_start) |=> $stable(cap_q)); // R5
endmodule

// File: rtl/apm_samp_reg.sv
`timescale 1ns/1ps
module apm_samp_reg #(
   parameter int STEP_W = apm_pkg::APM_STEP_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [STEP_W-1:0] wr_data,
   output logic [STEP_W-1:0] samp
);
   logic [STEP_W-1:0] samp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     samp_q <= '0;
      else if (wr_en) samp_q <= wr_data;
   end

   assign samp = samp_q;

   AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (samp_q == $past(wr_data))); // R8
endmodule

// File: rtl/antenna_phase_meter.sv
`timescale 1ns/1ps
module antenna_phase_meter #(
   parameter int STEP_W      = apm_pkg::APM_STEP_W_DEF,
   parameter int SYNC_STAGES = apm_pkg::APM_SYNC_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_tick,
   input  logic              carrier_ref,
   input  logic              tap_cmp,
   input  logic              samp_wr_en,
   input  logic [STEP_W-1:0] samp_wr_data,
   output logic [STEP_W-1:0] phase_code,
   output logic [STEP_W-1:0] samp_time,
   output logic              sample_strobe
);
   localparam int SYNC_W = 2;

   generate
      if (STEP_W < 2 || STEP_W > 12) begin : g_bad_w
         $error("antenna_phase_meter: STEP_W must be 2..12");
      end
   endgenerate

   logic [SYNC_W-1:0] raw_in, sync_in;
   logic              car_d, tap_d, period_start, tap_rise;
   logic [STEP_W-1:0] step_cnt, samp_q;

   assign raw_in = {tap_cmp, carrier_ref};

   apm_sync #(.N_BITS(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(sync_in)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         car_d <= 1'b0;
         tap_d <= 1'b0;
      end else begin
         car_d <= sync_in[0];
         tap_d <= sync_in[1];
      end
   end

   assign period_start = apm_pkg::rose(sync_in[0], car_d);
   assign tap_rise     = apm_pkg::rose(sync_in[1], tap_d);

   apm_samp_reg #(.STEP_W(STEP_W)) u_samp (
      .clk(clk), .rst_n(rst_n), .wr_en(samp_wr_en), .wr_data(samp_wr_data),
      .samp(samp_q)
   );

   apm_step_timer #(.STEP_W(STEP_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .step_tick(step_tick),
      .period_start(period_start), .samp_time(samp_q),
      .step_cnt(step_cnt), .strobe(sample_strobe)
   );

   apm_phase_capture #(.STEP_W(STEP_W)) u_capture (
      .clk(clk), .rst_n(rst_n), .period_start(period_start),
      .tap_rise(tap_rise), .step_cnt(step_cnt), .code(phase_code)
   );

   assign samp_time = samp_q;
endmodule

// File: tb/antenna_phase_meter_bench.sv
`timescale 1ns/1ps
module antenna_phase_meter_bench;
   localparam int W = 6;

   logic         clk = 1'b0;
   logic         rst_n, step_tick, carrier_ref, tap_cmp, wr_en;
   logic [W-1:0] wr_data;
   logic [W-1:0] phase_code, samp_time;
   logic         sample_strobe;

   always #5 clk = ~clk;

   antenna_phase_meter u_antenna_phase_meter (
      .clk(clk), .rst_n(rst_n), .step_tick(step_tick), .carrier_ref(carrier_ref),
      .tap_cmp(tap_cmp), .samp_wr_en(wr_en), .samp_wr_data(wr_data),
      .phase_code(phase_code), .samp_time(samp_time), .sample_strobe(sample_strobe)
   );

   int    checks = 0;
   int    errors = 0;
   int    exp_q[$];
   string lbl_q[$];
   event  chk_ev;
   int    samp_model = 0;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: pops the expected code for the running period
   initial begin
      forever begin
         @(chk_ev);
         if (exp_q.size() == 0) begin
            check("R2 scoreboard empty", 1, 0);
         end else begin
            int    e;
            string l;
            e = exp_q.pop_front();
            l = lbl_q.pop_front();
            check(l, int'(phase_code), e);
         end
      end
   end

   // mode 0: no tap edge, 1: one pulse at p, 2: two pulses starting at p
   task automatic run_period(input int mode, input int p, input bit do_wr,
                             input int wr_val, input bit chk_s, input string lbl,
                             input int exp, input int prev);
      int strobe_bad = 0;
      exp_q.push_back(exp);
      lbl_q.push_back(lbl);
      for (int s = 0; s < 64; s++) begin
         for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (chk_s && (sample_strobe !== (s == samp_model && c == 1))) strobe_bad++;
            if (s == 0 && c == 1) check("R3 code held before boundary", int'(phase_code), prev);
            if (s == 4 && c == 1) begin
               -> chk_ev;
               if (chk_s) check("R8 sampling time readback", int'(samp_time), samp_model);
            end
            if (s == 62 && c == 1) check("R3 code stable in period", int'(phase_code), exp);
            step_tick   = (c == 0);
            carrier_ref = (s < 32);
            case (mode)
               1:       tap_cmp = (s >= p && s < p + 8);
               2:       tap_cmp = (s >= p && s < p + 3) || (s >= p + 6 && s < p + 9);
               default: tap_cmp = 1'b0;
            endcase
            wr_en   = do_wr && s == 63 && c == 3;
            wr_data = W'(wr_val);
         end
      end
      if (chk_s) check("R9 one strobe at sampling step", strobe_bad, 0);
      if (do_wr) samp_model = wr_val;
   endtask

   initial begin
      rst_n = 1'b0; step_tick = 1'b0; carrier_ref = 1'b0; tap_cmp = 1'b0;
      wr_en = 1'b0; wr_data = '0;
      repeat (3) @(negedge clk);
      check("R1 reset phase code", int'(phase_code), 0);
      check("R1 reset sampling time", int'(samp_time), 0);
      check("R1 reset strobe", int'(sample_strobe), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 code after release", int'(phase_code), 0);
      // stray tap edge before any carrier edge (R7)
      tap_cmp = 1'b1;
      repeat (3) @(negedge clk);
      tap_cmp = 1'b0;
      repeat (4) @(negedge clk);

      run_period(1, 16, 1, 5,  0, "R7 stray edge ignored",     0,  0);
      run_period(1, 16, 0, 0,  1, "R2 quarter lag code 16",    16, 0);
      run_period(1, 3,  1, 0,  1, "R2 repeat lag 16",          16, 16);
      run_period(0, 0,  0, 0,  1, "R2 lag 3",                  3,  16);
      run_period(2, 45, 1, 63, 1, "R4 no edge keeps code",     3,  3);
      run_period(1, 0,  1, 40, 1, "R5 first of two edges",     45, 3);
      run_period(1, 63, 0, 0,  1, "R6 coincident edge gives 0", 0, 45);
      run_period(1, 20, 0, 0,  1, "R2 lag 63",                 63, 0);
      run_period(1, 7,  0, 0,  1, "R2 lag 20",                 20, 63);
      run_period(0, 0,  0, 0,  1, "R2 lag 7",                  7,  20);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule